// File: doc/BRIEF.md
# Paged Address Translator with Access Protection

This block turns byte addresses from a small logical space into addresses in a larger physical space, one page at a time. The logical space is 1024 bytes and is cut into four 256-byte pages. The physical space is 2048 bytes, which holds eight page slots. Each logical page has one table entry. An entry holds a presence flag, the physical slot the page occupies and a two-bit permission code. In that code, bit 0 grants reading and bit 1 grants writing.

The block has two independent command channels, and each uses a valid/ready handshake.

- **Map channel.** A map command binds a logical page to the next unused physical slot. Slots are handed out strictly in ascending order by a running pointer, and a slot is never returned.
- **Translate channel.** A translate command looks up the page, checks the requested access bits against the page's permission code, and returns either the physical address or a two-bit error code.

Each channel holds a single registered response until the consumer takes it.

Top module: `amt_translator`

## Requirements
- R1: After reset both request channels are ready, no response is pending, the slot pointer is zero and every page entry is absent, so a translate of any in-range address returns code 2.
- R2: A translate whose page index (address bits above bit 7) is 4 or more returns code 1 (out of range).
- R3: A map whose page index is 4 or more returns code 1, consumes no slot and changes no entry.
- R4: A successful map returns code 0 and a base equal to the pointer times 256, so slots are granted in the order 0x000, 0x100, 0x200 and upward. The pointer then advances by one page.
- R5: Once eight slots are used, an in-range map returns code 2 with base 0. The pointer and all entries stay unchanged.
- R6: A translate of an in-range page whose entry is absent returns code 2, whatever access is requested.
- R7: The access field uses bit 0 for read and bit 1 for write. A translate of a present page returns code 3 when (access AND permission) differs from access. An access value of 0 is always allowed.
- R8: A successful translate returns code 0 and the page base plus the low 8 address bits.
- R9: Every response with a nonzero code carries an address or base of zero.
- R10: Mapping a page that is already present takes a fresh slot and replaces both the slot and the permission of that entry.
- R11: When a map and a translate are accepted on the same clock edge, the translate is judged against the table as it stood before that map.
- R12: A response appears on the cycle after its request is accepted. It stays valid and unchanged while its ready input is low, and the request ready of that channel stays low meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_valid | input | 1 | Map request present |
| map_ready | output | 1 | Map request can be accepted |
| map_laddr | input | 12 | Logical address of the page to bind |
| map_prot | input | 2 | Permission code for the page (bit 0 read, bit 1 write) |
| map_rsp_valid | output | 1 | Map response present |
| map_rsp_ready | input | 1 | Map response taken |
| map_rsp_code | output | 2 | Map result: 0 ok, 1 out of range, 2 physical space full |
| map_rsp_base | output | 11 | Physical base granted to the page |
| xlt_valid | input | 1 | Translate request present |
| xlt_ready | output | 1 | Translate request can be accepted |
| xlt_laddr | input | 12 | Logical address to translate |
| xlt_acc | input | 2 | Requested access bits (bit 0 read, bit 1 write) |
| xlt_rsp_valid | output | 1 | Translate response present |
| xlt_rsp_ready | input | 1 | Translate response taken |
| xlt_rsp_code | output | 2 | 0 ok, 1 out of range, 2 absent, 3 access denied |
| xlt_rsp_paddr | output | 11 | Physical address, zero on error |

## Verification
The bench fills physical space through remaps until the ninth grant is refused. A pointer that wrapped, or that advanced on a refused or out-of-range map, would hand out a wrong base, and the following translate of the remapped page would come back with a shifted address. Translates use access value 0, reads on write-only pages and combined read/write requests on read-only pages. A permission check written as a plain overlap test would let a combined request through on a one-bit page. An absent page is probed with access 0, so checking permission before presence would report success instead of code 2. A map and a translate of the same page are issued on one edge, which catches a table that forwards the new entry into the lookup. The map response is then held back to show that it stays frozen and that new requests are refused while it waits.

// File: rtl/amt_pkg.sv
package amt_pkg;

  localparam int PROT_W = 2;

  typedef enum logic [1:0] {
    CODE_OK     = 2'd0,
    CODE_RANGE  = 2'd1,
    CODE_ABSENT = 2'd2,
    CODE_DENIED = 2'd3
  } amt_code_e;

  // Every requested bit must be granted by the page permission.
  function automatic logic perm_covers(input logic [PROT_W-1:0] want,
                                       input logic [PROT_W-1:0] have);
    return (want & have) == want;
  endfunction

endpackage

// File: rtl/amt_slot_alloc.sv
module amt_slot_alloc #(
  parameter int NSLOTS = 8,
  parameter int SLOT_W = $clog2(NSLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic              full,
  output logic [SLOT_W-1:0] count
);

  logic [SLOT_W-1:0] count_q;

  // The pointer only moves forward; a slot is never handed back.
  always_ff @(posedge clk) begin
    if (!rst_n)
      count_q <= '0;
    else if (take && !full)
      count_q <= count_q + SLOT_W'(1);
  end

  assign full  = (count_q >= SLOT_W'(NSLOTS));
  assign count = count_q;

endmodule

// File: rtl/amt_page_table.sv
module amt_page_table
  import amt_pkg::*;
#(
  parameter int NPAGES = 4,
  parameter int IDX_W  = $clog2(NPAGES),
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_present,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [PROT_W-1:0] rd_prot
);

  logic [NPAGES-1:0] present_q;
  logic [SLOT_W-1:0] slot_q [NPAGES];
  logic [PROT_W-1:0] prot_q [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_entry
    logic hit_w;
    assign hit_w = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        present_q[g] <= 1'b0;
        slot_q[g]    <= '0;
        prot_q[g]    <= '0;
      end else if (hit_w) begin
        present_q[g] <= 1'b1;
        slot_q[g]    <= wr_slot;
        prot_q[g]    <= wr_prot;
      end
    end
  end

  // The read port sees registered state only: a same-edge write is not forwarded.
  always_comb begin
    rd_present = 1'b0;
    rd_slot    = '0;
    rd_prot    = '0;
    for (int i = 0; i < NPAGES; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_present = present_q[i];
        rd_slot    = slot_q[i];
        rd_prot    = prot_q[i];
      end
    end
  end

endmodule

// File: rtl/amt_map_eval.sv
module amt_map_eval
  import amt_pkg::*;
#(
  parameter int LADDR_W = 12,
  parameter int OFS_W   = 8,
  parameter int NPAGES  = 4,
  parameter int IDX_W   = $clog2(NPAGES),
  parameter int SLOT_W  = 4,
  parameter int PADDR_W = 11
) (
  input  logic [LADDR_W-1:0] laddr,
  input  logic               full,
  input  logic [SLOT_W-1:0]  slot,
  output logic               in_range,
  output logic               commit,
  output logic [IDX_W-1:0]   idx,
  output amt_code_e          code,
  output logic [PADDR_W-1:0] base
);

  localparam int PIDX_W = LADDR_W - OFS_W;

  function automatic logic [PIDX_W-1:0] page_of(input logic [LADDR_W-1:0] a);
    return a[LADDR_W-1:OFS_W];
  endfunction

  function automatic logic [PADDR_W-1:0] slot_base(input logic [SLOT_W-1:0] s);
    return PADDR_W'(s) << OFS_W;
  endfunction

  logic [PIDX_W-1:0] pidx;

  assign pidx     = page_of(laddr);
  assign in_range = (pidx < PIDX_W'(NPAGES));
  assign idx      = pidx[IDX_W-1:0];

  // A range error takes precedence over an exhausted physical space.
  always_comb begin
    commit = 1'b0;
    base   = '0;
    if (!in_range) begin
      code = CODE_RANGE;
    end else if (full) begin
      code = CODE_ABSENT;
    end else begin
      code   = CODE_OK;
      commit = 1'b1;
      base   = slot_base(slot);
    end
  end

endmodule

// File: rtl/amt_xlt_eval.sv
module amt_xlt_eval
  import amt_pkg::*;
#(
  parameter int LADDR_W = 12,
  parameter int OFS_W   = 8,
  parameter int NPAGES  = 4,
  parameter int IDX_W   = $clog2(NPAGES),
  parameter int SLOT_W  = 4,
  parameter int PADDR_W = 11
) (
  input  logic [LADDR_W-1:0] laddr,
  input  logic [PROT_W-1:0]  acc,
  input  logic               ent_present,
  input  logic [SLOT_W-1:0]  ent_slot,
  input  logic [PROT_W-1:0]  ent_prot,
  output logic [IDX_W-1:0]   idx,
  output amt_code_e          code,
  output logic [PADDR_W-1:0] paddr
);

  localparam int PIDX_W = LADDR_W - OFS_W;

  function automatic logic [PIDX_W-1:0] page_of(input logic [LADDR_W-1:0] a);
    return a[LADDR_W-1:OFS_W];
  endfunction

  function automatic logic [OFS_W-1:0] offset_of(input logic [LADDR_W-1:0] a);
    return a[OFS_W-1:0];
  endfunction

  function automatic logic [PADDR_W-1:0] phys_of(input logic [SLOT_W-1:0] s,
                                                 input logic [OFS_W-1:0]  o);
    return (PADDR_W'(s) << OFS_W) + PADDR_W'(o);
  endfunction

  logic [PIDX_W-1:0] pidx;
  logic              in_range;

  assign pidx     = page_of(laddr);
  assign in_range = (pidx < PIDX_W'(NPAGES));
  assign idx      = pidx[IDX_W-1:0];

  // Checks in order: range, presence, permission.
  always_comb begin
    paddr = '0;
    if (!in_range) begin
      code = CODE_RANGE;
    end else if (!ent_present) begin
      code = CODE_ABSENT;
    end else if (!perm_covers(acc, ent_prot)) begin
      code = CODE_DENIED;
    end else begin
      code  = CODE_OK;
      paddr = phys_of(ent_slot, offset_of(laddr));
    end
  end

endmodule

// File: rtl/amt_translator.sv
module amt_translator
  import amt_pkg::*;
#(
  parameter int LOG_BYTES  = 1024,
  parameter int PHYS_BYTES = 2048,
  parameter int PAGE_BYTES = 256,
  parameter int LADDR_W    = 12,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int NPAGES    = LOG_BYTES / PAGE_BYTES,
  localparam int NSLOTS    = PHYS_BYTES / PAGE_BYTES,
  localparam int IDX_W     = $clog2(NPAGES),
  localparam int SLOT_W    = $clog2(NSLOTS + 1),
  localparam int PADDR_W   = $clog2(PHYS_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_valid,
  output logic               map_ready,
  input  logic [LADDR_W-1:0] map_laddr,
  input  logic [1:0]         map_prot,
  output logic               map_rsp_valid,
  input  logic               map_rsp_ready,
  output logic [1:0]         map_rsp_code,
  output logic [PADDR_W-1:0] map_rsp_base,
  input  logic               xlt_valid,
  output logic               xlt_ready,
  input  logic [LADDR_W-1:0] xlt_laddr,
  input  logic [1:0]         xlt_acc,
  output logic               xlt_rsp_valid,
  input  logic               xlt_rsp_ready,
  output logic [1:0]         xlt_rsp_code,
  output logic [PADDR_W-1:0] xlt_rsp_paddr
);

  // Named internal events, used by the bound checker.
  logic               map_fire;
  logic               xlt_fire;
  logic               alloc_full;
  logic [SLOT_W-1:0]  alloc_count;
  logic               map_in_range;
  logic               map_commit;
  logic [IDX_W-1:0]   map_idx;
  amt_code_e          map_code;
  logic [PADDR_W-1:0] map_base;
  logic [IDX_W-1:0]   xlt_idx;
  logic               ent_present;
  logic [SLOT_W-1:0]  ent_slot;
  logic [PROT_W-1:0]  ent_prot;
  amt_code_e          xlt_code;
  logic [PADDR_W-1:0] xlt_paddr;

  // A channel takes a new request when its response slot is free or draining.
  assign map_ready = !map_rsp_valid || map_rsp_ready;
  assign xlt_ready = !xlt_rsp_valid || xlt_rsp_ready;
  assign map_fire  = map_valid && map_ready;
  assign xlt_fire  = xlt_valid && xlt_ready;

  amt_slot_alloc #(
    .NSLOTS (NSLOTS),
    .SLOT_W (SLOT_W)
  ) u_alloc (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (map_fire && map_commit),
    .full  (alloc_full),
    .count (alloc_count)
  );

  amt_map_eval #(
    .LADDR_W (LADDR_W),
    .OFS_W   (OFS_W),
    .NPAGES  (NPAGES),
    .IDX_W   (IDX_W),
    .SLOT_W  (SLOT_W),
    .PADDR_W (PADDR_W)
  ) u_map_eval (
    .laddr    (map_laddr),
    .full     (alloc_full),
    .slot     (alloc_count),
    .in_range (map_in_range),
    .commit   (map_commit),
    .idx      (map_idx),
    .code     (map_code),
    .base     (map_base)
  );

  amt_page_table #(
    .NPAGES (NPAGES),
    .IDX_W  (IDX_W),
    .SLOT_W (SLOT_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (map_fire && map_commit),
    .wr_idx     (map_idx),
    .wr_slot    (alloc_count),
    .wr_prot    (map_prot),
    .rd_idx     (xlt_idx),
    .rd_present (ent_present),
    .rd_slot    (ent_slot),
    .rd_prot    (ent_prot)
  );

  amt_xlt_eval #(
    .LADDR_W (LADDR_W),
    .OFS_W   (OFS_W),
    .NPAGES  (NPAGES),
    .IDX_W   (IDX_W),
    .SLOT_W  (SLOT_W),
    .PADDR_W (PADDR_W)
  ) u_xlt_eval (
    .laddr       (xlt_laddr),
    .acc         (xlt_acc),
    .ent_present (ent_present),
    .ent_slot    (ent_slot),
    .ent_prot    (ent_prot),
    .idx         (xlt_idx),
    .code        (xlt_code),
    .paddr       (xlt_paddr)
  );

  // Map response register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_rsp_valid <= 1'b0;
      map_rsp_code  <= '0;
      map_rsp_base  <= '0;
    end else if (map_fire) begin
      map_rsp_valid <= 1'b1;
      map_rsp_code  <= map_code;
      map_rsp_base  <= map_base;
    end else if (map_rsp_ready) begin
      map_rsp_valid <= 1'b0;
    end
  end

  // Translate response register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlt_rsp_valid <= 1'b0;
      xlt_rsp_code  <= '0;
      xlt_rsp_paddr <= '0;
    end else if (xlt_fire) begin
      xlt_rsp_valid <= 1'b1;
      xlt_rsp_code  <= xlt_code;
      xlt_rsp_paddr <= xlt_paddr;
    end else if (xlt_rsp_ready) begin
      xlt_rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/amt_translator_chk.sv
module amt_translator_chk #(
  parameter int LADDR_W = 12,
  parameter int OFS_W   = 8,
  parameter int NSLOTS  = 8,
  parameter int SLOT_W  = 4,
  parameter int PADDR_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               map_fire,
  input logic               xlt_fire,
  input logic               map_in_range,
  input logic               alloc_full,
  input logic [SLOT_W-1:0]  alloc_count,
  input logic [LADDR_W-1:0] xlt_laddr,
  input logic               map_rsp_valid,
  input logic               map_rsp_ready,
  input logic               map_ready,
  input logic [1:0]         map_rsp_code,
  input logic [PADDR_W-1:0] map_rsp_base,
  input logic               xlt_rsp_valid,
  input logic               xlt_rsp_ready,
  input logic [1:0]         xlt_rsp_code,
  input logic [PADDR_W-1:0] xlt_rsp_paddr
);

  assert_slot_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_count <= SLOT_W'(NSLOTS));

  assert_bump_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    map_fire && map_in_range && !alloc_full |=>
      map_rsp_valid && map_rsp_code == 2'd0 &&
      alloc_count == $past(alloc_count) + SLOT_W'(1) &&
      map_rsp_base == (PADDR_W'($past(alloc_count)) << OFS_W));

  assert_full_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    map_fire && map_in_range && alloc_full |=>
      map_rsp_code == 2'd2 && map_rsp_base == '0 && $stable(alloc_count));

  assert_range_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_fire && !map_in_range |=> map_rsp_code == 2'd1 && $stable(alloc_count));

  assert_err_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_rsp_valid && xlt_rsp_code != 2'd0 |-> xlt_rsp_paddr == '0);

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_fire |=> xlt_rsp_code != 2'd0 ||
      xlt_rsp_paddr[OFS_W-1:0] == $past(xlt_laddr[OFS_W-1:0]));

  assert_map_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    map_rsp_valid && !map_rsp_ready |=>
      map_rsp_valid && $stable(map_rsp_code) && $stable(map_rsp_base));

  assert_xlt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_rsp_valid && !xlt_rsp_ready |=>
      xlt_rsp_valid && $stable(xlt_rsp_code) && $stable(xlt_rsp_paddr));

  assert_stall_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    map_rsp_valid && !map_rsp_ready |-> !map_ready);

endmodule

bind amt_translator amt_translator_chk #(
  .LADDR_W (LADDR_W),
  .OFS_W   (OFS_W),
  .NSLOTS  (NSLOTS),
  .SLOT_W  (SLOT_W),
  .PADDR_W (PADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .map_fire      (map_fire),
  .xlt_fire      (xlt_fire),
  .map_in_range  (map_in_range),
  .alloc_full    (alloc_full),
  .alloc_count   (alloc_count),
  .xlt_laddr     (xlt_laddr),
  .map_rsp_valid (map_rsp_valid),
  .map_rsp_ready (map_rsp_ready),
  .map_ready     (map_ready),
  .map_rsp_code  (map_rsp_code),
  .map_rsp_base  (map_rsp_base),
  .xlt_rsp_valid (xlt_rsp_valid),
  .xlt_rsp_ready (xlt_rsp_ready),
  .xlt_rsp_code  (xlt_rsp_code),
  .xlt_rsp_paddr (xlt_rsp_paddr)
);

// File: tb/amt_translator_tb.sv
module amt_translator_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_valid = 1'b0;
  logic        map_ready;
  logic [11:0] map_laddr = '0;
  logic [1:0]  map_prot = '0;
  logic        map_rsp_valid;
  logic        map_rsp_ready = 1'b1;
  logic [1:0]  map_rsp_code;
  logic [10:0] map_rsp_base;
  logic        xlt_valid = 1'b0;
  logic        xlt_ready;
  logic [11:0] xlt_laddr = '0;
  logic [1:0]  xlt_acc = '0;
  logic        xlt_rsp_valid;
  logic        xlt_rsp_ready = 1'b1;
  logic [1:0]  xlt_rsp_code;
  logic [10:0] xlt_rsp_paddr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  amt_translator u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .map_valid     (map_valid),
    .map_ready     (map_ready),
    .map_laddr     (map_laddr),
    .map_prot      (map_prot),
    .map_rsp_valid (map_rsp_valid),
    .map_rsp_ready (map_rsp_ready),
    .map_rsp_code  (map_rsp_code),
    .map_rsp_base  (map_rsp_base),
    .xlt_valid     (xlt_valid),
    .xlt_ready     (xlt_ready),
    .xlt_laddr     (xlt_laddr),
    .xlt_acc       (xlt_acc),
    .xlt_rsp_valid (xlt_rsp_valid),
    .xlt_rsp_ready (xlt_rsp_ready),
    .xlt_rsp_code  (xlt_rsp_code),
    .xlt_rsp_paddr (xlt_rsp_paddr)
  );

  int vectors = 0;
  int misses  = 0;

  // Reference model of the page table and pointer.
  bit          m_present [4];
  int          m_base    [4];
  int          m_prot    [4];
  int          m_used = 0;

  // Scoreboard queues: {code, address} plus the requirement under test.
  logic [12:0] map_q [$];
  string       map_tag_q [$];
  logic [12:0] xlt_q [$];
  string       xlt_tag_q [$];

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] model_map(input int addr, input int prot);
    int pg = addr >> 8;
    if (pg >= 4) return {2'd1, 11'd0};
    if (m_used + 256 > 2048) return {2'd2, 11'd0};
    m_present[pg] = 1'b1;
    m_base[pg]    = m_used;
    m_prot[pg]    = prot;
    m_used        = m_used + 256;
    return {2'd0, 11'(m_base[pg])};
  endfunction

  function automatic logic [12:0] model_xlt(input int addr, input int acc);
    int pg = addr >> 8;
    if (pg >= 4) return {2'd1, 11'd0};
    if (!m_present[pg]) return {2'd2, 11'd0};
    if ((acc & m_prot[pg]) != acc) return {2'd3, 11'd0};
    return {2'd0, 11'(m_base[pg] + (addr & 255))};
  endfunction

  task automatic drive_map(input int addr, input int prot, input string tag);
    @(negedge clk);
    map_valid = 1'b1;
    map_laddr = 12'(addr);
    map_prot  = 2'(prot);
    while (!map_ready) @(negedge clk);
    map_q.push_back(model_map(addr, prot));
    map_tag_q.push_back(tag);
    @(negedge clk);
    map_valid = 1'b0;
  endtask

  task automatic drive_xlt(input int addr, input int acc, input string tag);
    @(negedge clk);
    xlt_valid = 1'b1;
    xlt_laddr = 12'(addr);
    xlt_acc   = 2'(acc);
    while (!xlt_ready) @(negedge clk);
    xlt_q.push_back(model_xlt(addr, acc));
    xlt_tag_q.push_back(tag);
    @(negedge clk);
    xlt_valid = 1'b0;
  endtask

  // Map and translate on one edge: the translate is scored against the old table.
  task automatic drive_both(input int maddr, input int prot,
                            input int xaddr, input int acc, input string tag);
    @(negedge clk);
    map_valid = 1'b1; map_laddr = 12'(maddr); map_prot = 2'(prot);
    xlt_valid = 1'b1; xlt_laddr = 12'(xaddr); xlt_acc  = 2'(acc);
    while (!(map_ready && xlt_ready)) @(negedge clk);
    xlt_q.push_back(model_xlt(xaddr, acc));
    xlt_tag_q.push_back(tag);
    map_q.push_back(model_map(maddr, prot));
    map_tag_q.push_back(tag);
    @(negedge clk);
    map_valid = 1'b0;
    xlt_valid = 1'b0;
  endtask

  // Monitors: pop expected items as responses are taken.
  always @(negedge clk) begin
    if (rst_n && map_rsp_valid && map_rsp_ready) begin
      if (map_q.size() == 0) begin
        check("R12 unexpected map response", 1, 0);
      end else begin
        logic [12:0] e;
        string t;
        e = map_q.pop_front();
        t = map_tag_q.pop_front();
        check(t, int'({map_rsp_code, map_rsp_base}), int'(e));
      end
    end
    if (rst_n && xlt_rsp_valid && xlt_rsp_ready) begin
      if (xlt_q.size() == 0) begin
        check("R12 unexpected translate response", 1, 0);
      end else begin
        logic [12:0] e;
        string t;
        e = xlt_q.pop_front();
        t = xlt_tag_q.pop_front();
        check(t, int'({xlt_rsp_code, xlt_rsp_paddr}), int'(e));
      end
    end
  end

  bit timed_out = 1'b0;

  initial begin
    fork
      begin : main_seq
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 map_ready after reset", int'(map_ready), 1);
        check("R1 xlt_ready after reset", int'(xlt_ready), 1);
        check("R1 no map response after reset", int'(map_rsp_valid), 0);
        check("R1 no translate response after reset", int'(xlt_rsp_valid), 0);

        for (int p = 0; p < 4; p++) drive_xlt(p * 256 + 7, 0, "R1 R6 absent after reset");
        drive_xlt(12'h400, 1, "R2 first page past range");
        drive_xlt(12'hFFF, 3, "R2 top address");

        drive_map(12'h000, 3, "R4 first grant");
        drive_map(12'h150, 1, "R4 second grant");
        drive_map(12'h2FF, 2, "R4 third grant");

        drive_xlt(12'h050, 1, "R8 read on rw page");
        drive_xlt(12'h0FF, 3, "R8 last offset rw");
        drive_xlt(12'h1A0, 1, "R8 read on read page");
        drive_xlt(12'h150, 2, "R7 write on read page");
        drive_xlt(12'h1A0, 3, "R7 rw on read page");
        drive_xlt(12'h250, 1, "R7 read on write page");
        drive_xlt(12'h250, 2, "R8 write on write page");
        drive_xlt(12'h1A0, 0, "R7 access zero allowed");
        drive_xlt(12'h310, 0, "R6 absent beats access zero");

        drive_map(12'h400, 1, "R3 map out of range");
        drive_map(12'h300, 0, "R3 next grant unaffected");
        drive_xlt(12'h310, 1, "R7 read on no-permission page");
        drive_xlt(12'h310, 0, "R9 R8 zero access on no-permission page");

        drive_map(12'h100, 3, "R10 remap takes fresh slot");
        drive_xlt(12'h1A0, 2, "R10 remapped base and permission");

        drive_both(12'h200, 1, 12'h250, 2, "R11 same-edge translate sees old entry");
        drive_xlt(12'h250, 2, "R11 later translate sees new entry");

        drive_map(12'h000, 3, "R4 seventh grant");
        drive_map(12'h300, 3, "R4 eighth grant");
        drive_map(12'h100, 1, "R5 full refuses");
        drive_xlt(12'h1A0, 2, "R5 entry unchanged after refusal");
        drive_map(12'h800, 3, "R3 range precedes full");

        // Backpressure on the map response channel.
        @(negedge clk);
        map_rsp_ready = 1'b0;
        drive_map(12'h200, 3, "R12 held response");
        for (int k = 0; k < 3; k++) begin
          check("R12 response held", int'(map_rsp_valid), 1);
          check("R12 request blocked", int'(map_ready), 0);
          check("R12 code stable", int'(map_rsp_code), 2);
          @(negedge clk);
        end
        map_rsp_ready = 1'b1;

        repeat (4) @(negedge clk);
        check("R12 map queue drained", map_q.size(), 0);
        check("R12 translate queue drained", xlt_q.size(), 0);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check("R12 watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule